// File: doc/BRIEF.md
# Delay Buffer Read Address Generator

This block computes read addresses into a delay line that lives in external memory, and it issues the read requests. Software programs two base pointers, one for each delay line, and each base points at the newest sample of its line. To fetch the sample that lies N positions older, software writes N into the offset register. The fetch address is the chosen base minus N, and it wraps modulo 2^DW.

The offset register has a single storage location that answers at two bus addresses. The alias written picks the base: alias 0 at 0xFFE9 selects base 0, and alias 1 at 0xFFED selects base 1. While the trigger-select control bit is clear, the offset write itself launches the read. A downstream memory controller receives a request, an address and a base-select, and it answers with a one-cycle acknowledge.

The request logic is a three-state machine:
- `ST_IDLE`: no request is outstanding.
- `ST_BUSY`: one request is driven.
- `ST_BUSY_PEND`: one request is driven and one more is waiting.

Its transitions are:
- IDLE→BUSY on a trigger.
- BUSY→IDLE on acknowledge.
- BUSY→BUSY on acknowledge together with a trigger (the new request goes straight out).
- BUSY→BUSY_PEND on a trigger without acknowledge.
- BUSY_PEND→BUSY_PEND on a further trigger, which overwrites the waiting entry.
- BUSY_PEND→BUSY on acknowledge, which promotes the waiting entry or a simultaneous trigger.
- BUSY_PEND→BUSY on a software reset, which drops the waiting entry.
- BUSY_PEND→IDLE on a software reset together with acknowledge.

Top module: `delay_rd_addr_gen`

## Requirements
- R1: After hardware reset, the offset, both bases and the trigger-select bit read as zero, and no request is driven.
- R2: A write to 0xFFE9 or 0xFFED updates the same offset storage, and a read from either address returns it.
- R3: The request address equals (selected base − offset written) mod 2^DW, with no borrow indication.
- R4: While trigger-select is 0, a write to 0xFFE9 launches a request with req_sel=0, and a write to 0xFFED launches one with req_sel=1. The request appears the cycle after the write.
- R5: While trigger-select is 1 (bit 0 of the control register at 0xFFE2), offset writes update the offset but launch no request.
- R6: req_valid stays high until req_ack and falls the cycle after req_ack when nothing is waiting. Bit 1 of the control register reads back this busy state.
- R7: A trigger while busy is held as one waiting request, with its address computed at trigger time. It is issued the cycle after the acknowledge.
- R8: A later trigger while a request is waiting replaces the waiting one.
- R9: A one-cycle soft_rst clears the offset and drops any waiting request. An offset write in the same cycle is ignored, and the active request continues.
- R10: req_addr and req_sel stay stable while req_valid is high, until the cycle after req_ack.
- R11: req_ack while no request is driven has no effect.
- R12: Base 0 at 0xFFE0, base 1 at 0xFFE1 and the control register at 0xFFE2 are writable and read back at those addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| soft_rst | input | 1 | One-cycle software reset strobe |
| reg_addr | input | AW | Register port address |
| reg_wdata | input | DW | Register port write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | DW | Register read data (combinational) |
| req_valid | output | 1 | Read request to memory controller |
| req_addr | output | DW | Read address |
| req_sel | output | 1 | Base register used (0 or 1) |
| req_ack | input | 1 | Acknowledge from memory controller |

## Verification
The bench builds the block with DW=8 and AW=16, so the delay-line address space has 256 entries. At that width the bench can sweep every offset value against both aliases and against bases at zero, mid-range, the top and a small value. The sweep therefore covers every wrap-around case of the subtraction and every base-select pairing. Directed sequences then walk each state-machine transition, including overwrite of the waiting entry and a software reset while a request waits.

// File: rtl/dly_pkg.sv
package dly_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_BUSY      = 2'd1,
        ST_BUSY_PEND = 2'd2
    } req_state_e;
endpackage

// File: rtl/dly_regs.sv
module dly_regs #(
    parameter int AW = 16,
    parameter int DW = 24,
    parameter logic [AW-1:0] OFS0_ADDR  = 'hFFE9,
    parameter logic [AW-1:0] OFS1_ADDR  = 'hFFED,
    parameter logic [AW-1:0] BASE0_ADDR = 'hFFE0,
    parameter logic [AW-1:0] BASE1_ADDR = 'hFFE1,
    parameter logic [AW-1:0] CTRL_ADDR  = 'hFFE2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_we,
    input  logic          busy,
    output logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] base0_q,
    output logic [DW-1:0] base1_q,
    output logic [DW-1:0] offset_q,
    output logic          trig_sel_q,
    output logic          trig,
    output logic          trig_alias
);
    localparam int CTRL_PAD = DW - 2;

    logic hit_ofs0, hit_ofs1, hit_ofs;

    assign hit_ofs0   = (reg_addr == OFS0_ADDR);
    assign hit_ofs1   = (reg_addr == OFS1_ADDR);
    assign hit_ofs    = hit_ofs0 | hit_ofs1;
    assign trig       = reg_we && hit_ofs && !trig_sel_q && !soft_rst;
    assign trig_alias = hit_ofs1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset_q   <= '0;
            base0_q    <= '0;
            base1_q    <= '0;
            trig_sel_q <= 1'b0;
        end else begin
            if (soft_rst)
                offset_q <= '0;
            else if (reg_we && hit_ofs)
                offset_q <= reg_wdata;
            if (reg_we && reg_addr == BASE0_ADDR) base0_q <= reg_wdata;
            if (reg_we && reg_addr == BASE1_ADDR) base1_q <= reg_wdata;
            if (reg_we && reg_addr == CTRL_ADDR)  trig_sel_q <= reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_ofs)                       reg_rdata = offset_q;
        else if (reg_addr == BASE0_ADDR)   reg_rdata = base0_q;
        else if (reg_addr == BASE1_ADDR)   reg_rdata = base1_q;
        else if (reg_addr == CTRL_ADDR)    reg_rdata = {{CTRL_PAD{1'b0}}, busy, trig_sel_q};
    end
endmodule

// File: rtl/dly_addr_calc.sv
module dly_addr_calc #(
    parameter int DW = 24
) (
    input  logic [DW-1:0] base0,
    input  logic [DW-1:0] base1,
    input  logic [DW-1:0] offset,
    input  logic          sel,
    output logic [DW-1:0] addr
);
    logic [DW-1:0] base_pick;
    assign base_pick = sel ? base1 : base0;
    // modulo 2^DW: the borrow falls off the top
    assign addr = base_pick - offset;
endmodule

// File: rtl/dly_req_fsm.sv
module dly_req_fsm
    import dly_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          trig,
    input  logic          trig_alias,
    input  logic [DW-1:0] trig_addr,
    input  logic          req_ack,
    output logic          req_valid,
    output logic [DW-1:0] req_addr,
    output logic          req_sel
);
    req_state_e    state_q, state_d;
    logic [DW-1:0] act_addr_q, pend_addr_q;
    logic          act_sel_q, pend_sel_q;
    logic          load_act_new, load_act_pend, load_pend;

    always_comb begin
        state_d       = state_q;
        load_act_new  = 1'b0;
        load_act_pend = 1'b0;
        load_pend     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trig) begin
                    state_d      = ST_BUSY;
                    load_act_new = 1'b1;
                end
            end
            ST_BUSY: begin
                if (req_ack && trig) begin
                    load_act_new = 1'b1;
                end else if (req_ack) begin
                    state_d = ST_IDLE;
                end else if (trig) begin
                    state_d   = ST_BUSY_PEND;
                    load_pend = 1'b1;
                end
            end
            ST_BUSY_PEND: begin
                if (soft_rst) begin
                    state_d = req_ack ? ST_IDLE : ST_BUSY;
                end else if (req_ack && trig) begin
                    state_d      = ST_BUSY;
                    load_act_new = 1'b1;
                end else if (req_ack) begin
                    state_d       = ST_BUSY;
                    load_act_pend = 1'b1;
                end else if (trig) begin
                    load_pend = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_addr_q  <= '0;
            act_sel_q   <= 1'b0;
            pend_addr_q <= '0;
            pend_sel_q  <= 1'b0;
        end else begin
            if (load_act_new) begin
                act_addr_q <= trig_addr;
                act_sel_q  <= trig_alias;
            end else if (load_act_pend) begin
                act_addr_q <= pend_addr_q;
                act_sel_q  <= pend_sel_q;
            end
            if (load_pend) begin
                pend_addr_q <= trig_addr;
                pend_sel_q  <= trig_alias;
            end
        end
    end

    always_comb begin
        req_valid = (state_q != ST_IDLE);
        req_addr  = act_addr_q;
        req_sel   = act_sel_q;
    end
endmodule

// File: rtl/delay_rd_addr_gen.sv
module delay_rd_addr_gen #(
    parameter int AW = 16,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_we,
    output logic [DW-1:0] reg_rdata,
    output logic          req_valid,
    output logic [DW-1:0] req_addr,
    output logic          req_sel,
    input  logic          req_ack
);
    logic [DW-1:0] base0_q, base1_q, offset_q, trig_addr;
    logic          trig_sel_q, trig, trig_alias;

    dly_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .busy(req_valid), .reg_rdata(reg_rdata),
        .base0_q(base0_q), .base1_q(base1_q), .offset_q(offset_q),
        .trig_sel_q(trig_sel_q), .trig(trig), .trig_alias(trig_alias)
    );

    // the offset being written, not the stored one, forms the address
    dly_addr_calc #(.DW(DW)) u_calc (
        .base0(base0_q), .base1(base1_q), .offset(reg_wdata),
        .sel(trig_alias), .addr(trig_addr)
    );

    dly_req_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .trig(trig), .trig_alias(trig_alias), .trig_addr(trig_addr),
        .req_ack(req_ack), .req_valid(req_valid),
        .req_addr(req_addr), .req_sel(req_sel)
    );
endmodule

// File: rtl/dly_rd_chk.sv
module dly_rd_chk #(
    parameter int AW = 16,
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic [AW-1:0] reg_addr,
    input logic          reg_we,
    input logic          req_valid,
    input logic [DW-1:0] req_addr,
    input logic          req_sel,
    input logic          req_ack,
    input logic          trig_sel_q,
    input logic [DW-1:0] offset_q
);
    logic ofs_hit;
    assign ofs_hit = (reg_addr == AW'('hFFE9)) || (reg_addr == AW'('hFFED));

    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ack |=> req_valid);

    a_r10_stable_request: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ack |=> $stable(req_addr) && $stable(req_sel));

    a_r5_no_launch_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid && reg_we && ofs_hit && trig_sel_q |=> !req_valid);

    a_r4_launch_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid && reg_we && ofs_hit && !trig_sel_q && !soft_rst |=> req_valid);

    a_r9_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> offset_q == '0);

    a_r11_idle_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid && !reg_we |=> !req_valid);
endmodule

bind delay_rd_addr_gen dly_rd_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .reg_addr(reg_addr), .reg_we(reg_we),
    .req_valid(req_valid), .req_addr(req_addr), .req_sel(req_sel),
    .req_ack(req_ack), .trig_sel_q(trig_sel_q), .offset_q(offset_q)
);

// File: tb/tb_delay_rd_addr_gen.sv
module tb_delay_rd_addr_gen;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam logic [AW-1:0] A_OFS0  = 16'hFFE9;
    localparam logic [AW-1:0] A_OFS1  = 16'hFFED;
    localparam logic [AW-1:0] A_BASE0 = 16'hFFE0;
    localparam logic [AW-1:0] A_BASE1 = 16'hFFE1;
    localparam logic [AW-1:0] A_CTRL  = 16'hFFE2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic [DW-1:0] reg_rdata;
    logic          req_valid;
    logic [DW-1:0] req_addr;
    logic          req_sel;
    logic          req_ack = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    delay_rd_addr_gen #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_sel(req_sel), .req_ack(req_ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ack();
        @(negedge clk);
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
    endtask

    task automatic pulse_srst();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] bases [4];
        bases[0] = 8'd0; bases[1] = 8'd5; bases[2] = 8'd128; bases[3] = 8'd255;

        repeat (3) @(negedge clk);
        // R1 reset state
        rd(A_OFS0, v);  chk(v == 0, "R1 offset", v, 0);
        rd(A_BASE0, v); chk(v == 0, "R1 base0", v, 0);
        rd(A_BASE1, v); chk(v == 0, "R1 base1", v, 0);
        rd(A_CTRL, v);  chk(v == 0, "R1 ctrl", v, 0);
        chk(!req_valid, "R1 req_valid", req_valid, 0);
        rst_n = 1'b1;

        // R12 register readback
        wr(A_BASE0, 8'h3C); rd(A_BASE0, v); chk(v == 8'h3C, "R12 base0", v, 8'h3C);
        wr(A_BASE1, 8'hC3); rd(A_BASE1, v); chk(v == 8'hC3, "R12 base1", v, 8'hC3);
        wr(A_CTRL, 8'h01);  rd(A_CTRL, v);  chk(v == 8'h01, "R12 ctrl", v, 1);

        // R2 / R5 aliases share storage, no launch while select set
        wr(A_OFS0, 8'h5A);
        chk(!req_valid, "R5 no launch alias0", req_valid, 0);
        rd(A_OFS1, v); chk(v == 8'h5A, "R2 alias1 sees alias0 write", v, 8'h5A);
        wr(A_OFS1, 8'hA5);
        chk(!req_valid, "R5 no launch alias1", req_valid, 0);
        rd(A_OFS0, v); chk(v == 8'hA5, "R2 alias0 sees alias1 write", v, 8'hA5);
        wr(A_CTRL, 8'h00);

        // R11 ack when idle
        ack();
        chk(!req_valid, "R11 idle ack", req_valid, 0);

        // R3 / R4 / R6 sweep
        for (int b = 0; b < 4; b++) begin
            wr(A_BASE0, bases[b]);
            wr(A_BASE1, bases[3-b]);
            for (int al = 0; al < 2; al++) begin
                for (int o = 0; o < 256; o++) begin
                    logic [DW-1:0] exp_a;
                    exp_a = (al == 0) ? bases[b] - DW'(o) : bases[3-b] - DW'(o);
                    wr(al == 0 ? A_OFS0 : A_OFS1, DW'(o));
                    if (!req_valid || req_addr !== exp_a || req_sel !== al[0])
                        chk(1'b0, "R3/R4 sweep addr", req_addr, exp_a);
                    else
                        chk(1'b1, "R3", 0, 0);
                    ack();
                    chk(!req_valid, "R6 drop after ack", req_valid, 0);
                end
            end
        end

        // R6 busy bit and hold
        wr(A_BASE0, 8'd100);
        wr(A_OFS0, 8'd10);
        rd(A_CTRL, v); chk(v == 8'h02, "R6 busy bit", v, 2);
        repeat (3) @(negedge clk);
        chk(req_valid && req_addr == 8'd90, "R10 hold addr", req_addr, 90);

        // R7 pending: address fixed at trigger time
        wr(A_BASE1, 8'd50);
        wr(A_OFS1, 8'd7);            // waits, address 43 sel 1
        chk(req_addr == 8'd90 && req_sel == 1'b0, "R10 active unchanged", req_addr, 90);
        wr(A_BASE1, 8'd200);
        ack();
        chk(req_valid && req_addr == 8'd43 && req_sel, "R7 pending issued", req_addr, 43);
        ack();
        chk(!req_valid, "R7 idle after", req_valid, 0);

        // R8 overwrite
        wr(A_OFS0, 8'd1);            // active 99
        wr(A_OFS0, 8'd2);            // pending 98
        wr(A_OFS1, 8'd3);            // pending 197 sel1
        ack();
        chk(req_valid && req_addr == 8'd197 && req_sel, "R8 last pending wins", req_addr, 197);
        ack();
        chk(!req_valid, "R8 single pending", req_valid, 0);

        // R9 soft reset drops pending, keeps active, clears offset
        wr(A_OFS0, 8'd4);            // active 96
        wr(A_OFS0, 8'd5);            // pending 95
        pulse_srst();
        rd(A_OFS1, v); chk(v == 0, "R9 offset cleared", v, 0);
        chk(req_valid && req_addr == 8'd96, "R9 active kept", req_addr, 96);
        ack();
        chk(!req_valid, "R9 pending dropped", req_valid, 0);
        // soft reset wins over offset write
        @(negedge clk);
        reg_addr = A_OFS0; reg_wdata = 8'd9; reg_we = 1'b1; soft_rst = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; soft_rst = 1'b0;
        chk(!req_valid, "R9 no launch with srst", req_valid, 0);
        rd(A_OFS0, v); chk(v == 0, "R9 write ignored", v, 0);

        // R4 ack and trigger together in busy: new request direct
        wr(A_OFS0, 8'd0);            // active 100
        @(negedge clk);
        reg_addr = A_OFS1; reg_wdata = 8'd100; reg_we = 1'b1; req_ack = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; req_ack = 1'b0;
        chk(req_valid && req_addr == 8'd100 && req_sel, "R4 back-to-back", req_addr, 100);
        ack();
        chk(!req_valid, "R6 final idle", req_valid, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule